// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block accepts received Ethernet frames as a byte stream and stores them, one after another, in a circular receive buffer held in an external byte-wide memory. Each frame is given a 4-byte header in front of its data. The header carries a 16-bit status word and the 16-bit frame length. The next frame always starts on a 4-byte boundary. Data bytes go out as soon as they arrive. The header is written in the four cycles after the last byte, so a header never describes data that is not yet in memory.

The host consumes frames by writing a read-pointer register. That register holds the consumed offset minus 16. The block compares the read offset with its own committed write offset to drive a buffer-empty flag, which the host polls. A frame that would run into unread data is dropped whole. Bytes that arrive while a header is being written are lost for that whole frame. Both losses raise a write-one-to-clear status bit and advance a 24-bit missed-frame counter.

Top module: `rxr_writer`

## Requirements
- R1: The ring length is 2^BASE_LOG2 << idx bytes, where idx is bits [1:0] of the config register (address 2); an idx of 3 behaves as 2. Every memory address is taken modulo the ring length.
- R2: Byte k (from 0) of a stored frame is written at (frameStart + 4 + k) mod length, in the cycle it is presented.
- R3: The header occupies frameStart..frameStart+3 as a little-endian 32-bit word, with the length (bytes received, including FCS) in [31:16] and the status in [15:0]. It is written over the four cycles that follow the last byte.
- R4: Status word: bit0 set when no error flag is present; bits 1..5 copy the error inputs (inErr[0] alignment, [1] CRC, [2] too long, [3] runt, [4] bad symbol); bits 13, 14 and 15 copy inKind[0] broadcast, [1] own-address match and [2] multicast; all other bits are 0.
- R5: The next frame starts at (frameStart + length + 4 + 3) with the two low bits cleared, modulo the length.
- R6: The read-pointer register (address 0, 16 bits) holds the host's consumed offset minus 16 and resets to 0xFFF0. bufEmpty, also bit0 of the command register (address 1), is 1 exactly when the read offset equals the committed write offset.
- R7: The interrupt status register (address 3) has these bits: bit0 set by a stored frame with no errors, bit1 set by a stored frame with errors, bit4 set by an overflow drop, bit6 set by a header-time overrun. Writing a 1 to a bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: The missed-frame counter (address 4, 24 bits) counts each dropped or lost frame. Any write to it clears it.
- R9: A frame is stored only if its aligned footprint (length + 4 rounded up to a multiple of 4) is strictly smaller than the free space, which is the ring length when empty. Otherwise the frame is dropped: the write offset is unchanged, no byte lands in unread data, bit4 is set and the counter advances.
- R10: A frame whose first byte arrives during the four header cycles is lost, together with all of its bytes up to and including its last. It sets bit6 and advances the counter once.
- R11: After reset the write offset is 0, the buffer is empty, the interrupt status, config and missed counter are 0, and memWe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Frame byte present |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inErr | input | 5 | Error flags, sampled with the last byte |
| inKind | input | 3 | Address class flags, sampled with the last byte |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | BASE_LOG2+MAX_IDX | Buffer byte address |
| memData | output | 8 | Buffer write data |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| bufEmpty | output | 1 | No unread frame in the ring |

## Verification
Frames of random length carry random error and class flags. Some are sent with idle gaps inside them and the host consumes frames at random, so the ring fills, drops frames and wraps. These runs show whether the footprint, alignment and modulo arithmetic agree with the model over many placements. Directed cases cover the rest. One frame straddles the ring end, which separates correct wrap addressing from linear addressing. A set of three frames needs just above, exactly and just below the free space, which pins the strict comparison. Frames sent back to back, with the second one short or long, show whether overrun losses end at the right byte. A config value of 3 on a larger ring tells the clamp apart from other readings.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef struct packed {
    logic       byteIn;
    logic       hdrWr;
    logic [1:0] hdrIdx;
    logic       hdrDone;
    logic       lostFrame;
  } rxrStrobe_t;

  localparam logic [2:0] REG_RDPTR = 3'd0;
  localparam logic [2:0] REG_CMD   = 3'd1;
  localparam logic [2:0] REG_CFG   = 3'd2;
  localparam logic [2:0] REG_ISR   = 3'd3;
  localparam logic [2:0] REG_MISS  = 3'd4;

  localparam int ISR_OK  = 0;
  localparam int ISR_ERR = 1;
  localparam int ISR_OVF = 4;
  localparam int ISR_FOV = 6;
  localparam logic [15:0] ISR_MASK = 16'h0053;
endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       commitOk,
  output rxrStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_HDR, ST_DROP} state_t;

  state_t     stQ, stNext;
  logic       ovrQ, ovrNext;
  logic [1:0] hdrCntQ, hdrCntNext;

  always_comb begin
    strb       = '0;
    stNext     = stQ;
    ovrNext    = ovrQ;
    hdrCntNext = hdrCntQ;
    case (stQ)
      ST_IDLE, ST_RECV: begin
        if (inValid) begin
          strb.byteIn = 1'b1;
          if (inLast) begin
            stNext     = commitOk ? ST_HDR : ST_IDLE;
            hdrCntNext = 2'd0;
          end else begin
            stNext = ST_RECV;
          end
        end
      end
      ST_HDR: begin
        strb.hdrWr  = 1'b1;
        strb.hdrIdx = hdrCntQ;
        if (inValid) begin
          if (!ovrQ) strb.lostFrame = 1'b1;
          ovrNext = !inLast;
        end
        hdrCntNext = hdrCntQ + 2'd1;
        if (hdrCntQ == 2'd3) begin
          strb.hdrDone = 1'b1;
          stNext       = ovrNext ? ST_DROP : ST_IDLE;
        end
      end
      default: begin
        if (inValid && inLast) begin
          ovrNext = 1'b0;
          stNext  = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ     <= ST_IDLE;
      ovrQ    <= 1'b0;
      hdrCntQ <= 2'd0;
    end else begin
      stQ     <= stNext;
      ovrQ    <= ovrNext;
      hdrCntQ <= hdrCntNext;
    end
  end
endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int MAX_IDX   = 2,
  localparam int AW       = BASE_LOG2 + MAX_IDX
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxrStrobe_t    strb,
  input  logic [7:0]    inData,
  input  logic          inLast,
  input  logic [4:0]    inErr,
  input  logic [2:0]    inKind,
  input  logic          regWe,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  output logic          commitOk,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memData,
  output logic          bufEmpty,
  output logic [AW-1:0] wrOffQ,
  output logic [AW-1:0] rdOff,
  output logic [AW-1:0] lenMask,
  output logic [15:0]   isrQ,
  output logic [23:0]   missedQ
);
  logic [15:0]   rdPtrQ;
  logic [1:0]    sizeIdxQ, effIdx;
  logic [AW:0]   cntQ, lenFull, freeB;
  logic          dropQ;
  logic [31:0]   hdrQ;
  logic [AW+1:0] needQ, needNew, bytePos;
  logic [AW-1:0] freeRaw;
  logic [15:0]   rdSum, statWord, isrSet, isrClr;
  logic          fits, missInc;

  assign effIdx  = (sizeIdxQ > 2'(MAX_IDX)) ? 2'(MAX_IDX) : sizeIdxQ;
  assign lenFull = (AW+1)'(1) << (BASE_LOG2 + int'(effIdx));
  assign lenMask = AW'(lenFull - (AW+1)'(1));
  assign rdSum   = rdPtrQ + 16'd16;
  assign rdOff   = AW'(rdSum) & lenMask;
  assign freeRaw = (rdOff - wrOffQ) & lenMask;
  assign freeB   = (freeRaw == '0) ? lenFull : {1'b0, freeRaw};
  assign bufEmpty = (freeRaw == '0);

  assign bytePos  = (AW+2)'(cntQ) + (AW+2)'(4);
  assign needNew  = ((AW+2)'(cntQ) + (AW+2)'(8)) & ~(AW+2)'(3);
  assign fits     = bytePos < (AW+2)'(freeB);
  assign commitOk = !dropQ && fits && (needNew < (AW+2)'(freeB));
  assign statWord = {inKind, 7'b0, inErr, ~|inErr};

  always_comb begin
    memWe   = 1'b0;
    memAddr = '0;
    memData = '0;
    if (strb.byteIn && fits && !dropQ) begin
      memWe   = 1'b1;
      memAddr = (wrOffQ + AW'(cntQ) + AW'(4)) & lenMask;
      memData = inData;
    end else if (strb.hdrWr) begin
      memWe   = 1'b1;
      memAddr = (wrOffQ + AW'(strb.hdrIdx)) & lenMask;
      memData = hdrQ[8*strb.hdrIdx +: 8];
    end
  end

  always_comb begin
    isrSet          = '0;
    isrSet[ISR_OK]  = strb.hdrDone && hdrQ[0];
    isrSet[ISR_ERR] = strb.hdrDone && !hdrQ[0];
    isrSet[ISR_OVF] = strb.byteIn && inLast && !commitOk;
    isrSet[ISR_FOV] = strb.lostFrame;
    isrClr  = (regWe && regAddr == REG_ISR) ? (regWrData[15:0] & ISR_MASK) : '0;
    missInc = isrSet[ISR_OVF] || isrSet[ISR_FOV];
  end

  always_comb begin
    case (regAddr)
      REG_RDPTR: regRdData = {16'd0, rdPtrQ};
      REG_CMD:   regRdData = {31'd0, bufEmpty};
      REG_CFG:   regRdData = {30'd0, sizeIdxQ};
      REG_ISR:   regRdData = {16'd0, isrQ};
      REG_MISS:  regRdData = {8'd0, missedQ};
      default:   regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtrQ   <= 16'hFFF0;
      sizeIdxQ <= '0;
      isrQ     <= '0;
      missedQ  <= '0;
      wrOffQ   <= '0;
      cntQ     <= '0;
      dropQ    <= 1'b0;
      hdrQ     <= '0;
      needQ    <= '0;
    end else begin
      if (regWe && regAddr == REG_RDPTR) rdPtrQ   <= regWrData[15:0];
      if (regWe && regAddr == REG_CFG)   sizeIdxQ <= regWrData[1:0];
      isrQ <= (isrQ & ~isrClr) | isrSet;
      if (regWe && regAddr == REG_MISS) missedQ <= '0;
      else if (missInc)                 missedQ <= missedQ + 24'd1;
      if (strb.byteIn) begin
        if (fits && !dropQ) cntQ  <= cntQ + (AW+1)'(1);
        else                dropQ <= 1'b1;
        if (inLast) begin
          if (commitOk) begin
            hdrQ  <= {16'(cntQ) + 16'd1, statWord};
            needQ <= needNew;
          end else begin
            cntQ  <= '0;
            dropQ <= 1'b0;
          end
        end
      end
      if (strb.hdrDone) begin
        wrOffQ <= (wrOffQ + AW'(needQ)) & lenMask;
        cntQ   <= '0;
      end
    end
  end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int MAX_IDX   = 2,
  localparam int AW       = BASE_LOG2 + MAX_IDX
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inLast,
  input  logic [4:0]    inErr,
  input  logic [2:0]    inKind,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memData,
  input  logic          regWe,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  output logic          bufEmpty
);
  rxrStrobe_t    strb;
  logic          commitOk;
  logic [AW-1:0] wrOffQ, rdOff, lenMask;
  logic [15:0]   isrQ;
  logic [23:0]   missedQ;

  rxr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .commitOk(commitOk), .strb(strb)
  );

  rxr_datapath #(.BASE_LOG2(BASE_LOG2), .MAX_IDX(MAX_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .inLast(inLast),
    .inErr(inErr), .inKind(inKind), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .commitOk(commitOk),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .bufEmpty(bufEmpty),
    .wrOffQ(wrOffQ), .rdOff(rdOff), .lenMask(lenMask), .isrQ(isrQ),
    .missedQ(missedQ)
  );
endmodule

// File: rtl/rxr_writer_chk.sv
module rxr_writer_chk
  import rxr_pkg::*;
#(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rstN,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          bufEmpty,
  input logic          regWe,
  input logic [2:0]    regAddr,
  input rxrStrobe_t    strb,
  input logic [AW-1:0] wrOffQ,
  input logic [AW-1:0] rdOff,
  input logic [AW-1:0] lenMask,
  input logic [15:0]   isrQ,
  input logic [23:0]   missedQ
);
  // R9: no write lands inside the unread region [read offset, write offset)
  assert_unread_safe_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !bufEmpty) |->
      (((memAddr - wrOffQ) & lenMask) < ((rdOff - wrOffQ) & lenMask)));

  assert_aligned_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrOffQ[1:0] == 2'b00);

  assert_empty_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(bufEmpty) && !$past(regWe && regAddr == REG_RDPTR)) |-> $past(strb.hdrDone));

  assert_hdr_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.hdrDone |-> (memWe && strb.hdrIdx == 2'd3));

  assert_missed_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == REG_MISS) |=> (missedQ == 24'd0));

  assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.lostFrame |=> isrQ[ISR_FOV]);
endmodule

bind rxr_writer rxr_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .bufEmpty(bufEmpty),
  .regWe(regWe), .regAddr(regAddr), .strb(strb), .wrOffQ(wrOffQ), .rdOff(rdOff),
  .lenMask(lenMask), .isrQ(isrQ), .missedQ(missedQ)
);

// File: tb/rxr_writer_bench.sv
`timescale 1ns/1ps
module rxr_writer_bench;
  localparam int BL = 6;
  localparam int MI = 2;
  localparam int AW = BL + MI;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0, inLast = 1'b0;
  logic [7:0]    inData = '0;
  logic [4:0]    inErr = '0;
  logic [2:0]    inKind = '0;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;
  logic          regWe = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          bufEmpty;

  always #2.5 clk = ~clk;

  rxr_writer #(.BASE_LOG2(BL), .MAX_IDX(MI)) u_rxr_writer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inErr(inErr), .inKind(inKind), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .bufEmpty(bufEmpty)
  );

  logic [7:0] mem [0:(1<<AW)-1];
  always @(posedge clk) if (memWe) mem[memAddr] <= memData;

  int nVec = 0, nFail = 0;
  bit done = 1'b0;
  int expWr, ringLen, missedExp;
  logic [15:0] isrExp, ptrVal;
  logic [7:0]  fbuf [0:511];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
  endtask

  task automatic regWr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic idle(int c);
    inValid = 1'b0; inLast = 1'b0;
    repeat (c) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; regWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expWr = 0; ringLen = 1 << BL; missedExp = 0; isrExp = '0; ptrVal = 16'hFFF0;
  endtask

  task automatic setIdx(int idx);
    regWr(3'd2, 32'(idx));
    ringLen = (1 << BL) << ((idx > 2) ? 2 : idx);
  endtask

  function automatic int freeBytes();
    int rd, f;
    rd = (int'(ptrVal) + 16) & (ringLen - 1);
    f  = (rd - expWr) & (ringLen - 1);
    return (f == 0) ? ringLen : f;
  endfunction

  function automatic logic [15:0] statOf(logic [4:0] e, logic [2:0] k);
    return {k, 7'b0, e, (e == 5'd0)};
  endfunction

  task automatic sendFrame(int n, logic [4:0] e, logic [2:0] k, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1; inData = fbuf[i]; inLast = (i == n - 1);
      inErr = e; inKind = k;
      @(negedge clk);
    end
  endtask

  task automatic fillBuf(int n);
    for (int i = 0; i < n; i++) fbuf[i] = 8'($urandom);
  endtask

  task automatic verifyStore(int n, logic [4:0] e, logic [2:0] k, string req);
    logic [31:0] hdr;
    int bad, need, a;
    for (int i = 0; i < 4; i++) hdr[8*i +: 8] = mem[(expWr + i) & (ringLen - 1)];
    chk({req, " R3 R4 header"}, hdr, {16'(n), statOf(e, k)});
    bad = 0;
    for (int i = 0; i < n; i++) begin
      a = (expWr + 4 + i) & (ringLen - 1);
      if (mem[a] !== fbuf[i]) bad++;
    end
    chk({req, " R2 data bytes wrong"}, 32'(bad), 32'd0);
    need = (n + 7) & ~3;
    expWr = (expWr + need) & (ringLen - 1);
    isrExp = isrExp | ((e == 5'd0) ? 16'h0001 : 16'h0002);
    chk({req, " R6 not empty after store"}, 32'(bufEmpty), 32'd0);
  endtask

  task automatic runFrame(int n, logic [4:0] e, logic [2:0] k, bit gaps, string req);
    bit commit;
    logic [31:0] v;
    fillBuf(n);
    commit = (((n + 7) & ~3) < freeBytes());
    sendFrame(n, e, k, gaps);
    idle(6);
    if (commit) verifyStore(n, e, k, req);
    else begin
      missedExp++;
      isrExp = isrExp | 16'h0010;
      regRd(3'd4, v);
      chk({req, " R9 R8 missed count after drop"}, v, 32'(missedExp));
    end
  endtask

  task automatic consumeAll();
    logic [31:0] v;
    ptrVal = 16'(expWr - 16);
    regWr(3'd0, {16'd0, ptrVal});
    regRd(3'd1, v);
    chk("R6 empty after consume", v, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] oldHdr;
    void'($urandom(32'd20240611));
    doReset();

    // R11 reset state
    chk("R11 memWe low", 32'(memWe), 32'd0);
    regRd(3'd0, v); chk("R6 R11 read pointer reset", v, 32'h0000FFF0);
    regRd(3'd1, v); chk("R11 empty at reset", v, 32'd1);
    regRd(3'd2, v); chk("R11 config reset", v, 32'd0);
    regRd(3'd3, v); chk("R11 isr reset", v, 32'd0);
    regRd(3'd4, v); chk("R11 missed reset", v, 32'd0);

    // R2 R3 R4 R5 on a 64-byte ring
    setIdx(0);
    runFrame(10, 5'd0, 3'b001, 1'b0, "R5 first");
    chk("R5 next start", 32'(expWr), 32'd16);
    runFrame(5, 5'b00010, 3'b010, 1'b0, "R4 crc frame");
    chk("R5 second next", 32'(expWr), 32'd28);
    regRd(3'd3, v); chk("R7 ok and err bits", v, 32'h0003);
    regWr(3'd3, 32'h0001); isrExp = 16'h0002;
    regRd(3'd3, v); chk("R7 write-one clears only bit0", v, 32'h0002);
    regWr(3'd3, 32'hFFFF); isrExp = '0;

    // R1 wrap across ring end
    consumeAll();
    runFrame(40, 5'b10101, 3'b100, 1'b0, "R1 wrap frame");
    chk("R1 wrapped next start", 32'(expWr), 32'd8);

    // R9 boundary: free space is 20
    for (int i = 0; i < 4; i++) oldHdr[8*i +: 8] = mem[28 + i];
    runFrame(17, 5'd0, 3'd0, 1'b0, "R9 too big");
    runFrame(13, 5'd0, 3'd0, 1'b0, "R9 exact fit rejected");
    chk("R9 write offset unchanged", 32'(expWr), 32'd8);
    for (int i = 0; i < 4; i++) v[8*i +: 8] = mem[28 + i];
    chk("R9 unread header intact", v, oldHdr);
    regRd(3'd3, v); chk("R7 R9 overflow bit", v, 32'(isrExp));
    runFrame(12, 5'd0, 3'd0, 1'b0, "R9 just fits");
    chk("R9 fitting frame next", 32'(expWr), 32'd24);
    regWr(3'd4, 32'h0);
    missedExp = 0;
    regRd(3'd4, v); chk("R8 cleared by write", v, 32'd0);
    regWr(3'd3, 32'h0010); isrExp = isrExp & ~16'h0010;
    regRd(3'd3, v); chk("R7 clear overflow only", v, 32'(isrExp));
    regWr(3'd3, 32'hFFFF); isrExp = '0;

    // R10 back-to-back: long then short follower
    consumeAll();
    fillBuf(8);
    sendFrame(8, 5'd0, 3'd0, 1'b0);
    sendFrame(6, 5'd0, 3'd0, 1'b0);
    idle(4);
    verifyStore(8, 5'd0, 3'd0, "R10 leader");
    regRd(3'd4, v); chk("R10 missed after long overrun", v, 32'd1);
    regRd(3'd3, v); chk("R10 fifo over bit", v, 32'h0041);
    runFrame(5, 5'd0, 3'd0, 1'b0, "R10 after long overrun placement");
    consumeAll();
    fillBuf(8);
    sendFrame(8, 5'd0, 3'd0, 1'b0);
    sendFrame(2, 5'd0, 3'd0, 1'b0);
    idle(4);
    verifyStore(8, 5'd0, 3'd0, "R10 leader2");
    regRd(3'd4, v); chk("R10 missed after short overrun", v, 32'd2);
    runFrame(7, 5'd0, 3'd0, 1'b0, "R10 after short overrun placement");

    // R1 clamp of idx 3 onto 256-byte ring
    doReset();
    setIdx(3);
    regRd(3'd2, v); chk("R1 config readback", v, 32'd3);
    for (int f = 0; f < 7; f++) begin
      runFrame(40, 5'd0, 3'd0, 1'b0, "R1 clamp ring");
      consumeAll();
    end
    chk("R1 clamp wrap offset", 32'(expWr), 32'd52);

    // random traffic on a 128-byte ring
    doReset();
    setIdx(1);
    for (int f = 0; f < 60; f++) begin
      int n;
      logic [4:0] e;
      n = 1 + ($urandom % 48);
      e = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      runFrame(n, e, 3'($urandom), 1'($urandom), "R9 random");
      regRd(3'd3, v); chk("R7 random isr", v, 32'(isrExp));
      regWr(3'd3, 32'hFFFF); isrExp = '0;
      if ($urandom % 10 < 4) consumeAll();
    end
    regRd(3'd4, v); chk("R8 random missed total", v, 32'(missedExp));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule